// File: doc/BRIEF.md
# Cache-Line Write Command Selector

This block sits between a DMA write engine and the system bus master. It takes one write request at a time, given as a start address, a count of 32-bit words, an invalidate-enable bit and the 8-bit cache-line-size register value. It cuts the request into bursts and, for each burst, chooses between the ordinary memory-write command and the memory-write-and-invalidate command.

An invalidating burst is only allowed when the enable bit is set and the line size is 8 or 16 words. Such a burst always covers exactly one whole cache line that starts on a line boundary. When the start address is not aligned, a leading ordinary burst runs up to the next boundary. A trailing remainder shorter than one line is also sent as an ordinary burst. In every other case, including an unsupported line size, the whole request goes out as ordinary bursts of at most `MAX_BURST` words.

The block issues one burst per clock, beginning in the cycle after it accepts the request. Each burst carries its command code, its length in words and its byte address. Bus signalling and the data path are handled elsewhere.

Top module: `wr_cmd_splitter`

## Requirements
- R1: After reset, req_ready_o is 1 and burst_start_o is 0.
- R2: The invalidate command (burst_cmd_o = 4'b1111) is issued only when mwi_en_i was 1 at request acceptance. With mwi_en_i = 0, every burst uses the plain write code 4'b0111.
- R3: line_size_i holds the line size in 32-bit words. Only the values 8'h08 and 8'h10 enable invalidate bursts. Any other value makes every burst a plain write, even when mwi_en_i is 1.
- R4: An invalidate burst starts on a byte address that is a multiple of 4×line size and has a length equal to the line size in words.
- R5: With invalidation allowed and an unaligned start word address, the first burst is a plain write. Its length is the number of words up to the next line boundary, or the requested count if that is smaller.
- R6: With invalidation allowed, an aligned remainder smaller than one line is sent as one plain write burst of that many words.
- R7: When invalidation is not allowed, the bursts are plain writes. Each burst has min(remaining words, MAX_BURST) words.
- R8: Command codes are 4'b0111 for memory write and 4'b1111 for memory write and invalidate.
- R9: A request is accepted on a clock edge where req_valid_i and req_ready_o are both 1. Bursts then follow on consecutive cycles, starting one cycle after acceptance. Each burst's address is the previous burst's address plus 4×length, and the lengths sum to the requested count. req_ready_o returns to 1 in the cycle the last burst is shown.
- R10: A request with a zero word count produces no burst, and req_ready_o stays 1.
- R11: While req_ready_o is 0, req_valid_i and the other request inputs have no effect on the bursts in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Write request present |
| req_ready_o | output | 1 | Idle; can accept a request |
| req_addr_i | input | ADDR_W (32) | Start byte address, word aligned |
| req_words_i | input | CNT_W (16) | Number of 32-bit words |
| mwi_en_i | input | 1 | Allow the invalidate command |
| line_size_i | input | 8 | Cache-line-size register byte, in words |
| burst_start_o | output | 1 | One-cycle strobe for a new burst |
| burst_cmd_o | output | 4 | Bus command code for the burst |
| burst_len_o | output | LEN_W (5) | Burst length in 32-bit words |
| burst_addr_o | output | ADDR_W (32) | Byte address of the burst |

## Verification
Assertions are evaluated on every cycle. They check that an invalidate burst only appears with enable set and a supported line size, and that it is aligned and exactly one line long. They also check that burst lengths are non-zero and stay within both the remainder and MAX_BURST, that consecutive bursts advance the address by their length, and that a zero-count request leaves the block idle. The exact split of a request depends on how the address and count sit against line boundaries: the head length, the number of full lines and the tail. Those splits, the command choice for each line-size value, and the fact that requests arriving mid-transfer are ignored are shown only by the bench. It compares every burst against a model over directed and random requests.

// File: rtl/wr_cmd_pkg.sv
package wr_cmd_pkg;
  typedef logic [3:0] bus_cmd_t;
  localparam bus_cmd_t CMD_MEM_WR  = 4'b0111;
  localparam bus_cmd_t CMD_MEM_WRI = 4'b1111;
  localparam logic [7:0] LSZ_8W  = 8'h08;
  localparam logic [7:0] LSZ_16W = 8'h10;
endpackage

// File: rtl/line_cfg_decode.sv
module line_cfg_decode
  import wr_cmd_pkg::*;
(
  input  logic       en_i,
  input  logic [7:0] size_i,
  output logic       line_ok_o,
  output logic       line_big_o
);
  logic is8, is16;
  always_comb begin
    is8        = (size_i == LSZ_8W);
    is16       = (size_i == LSZ_16W);
    line_ok_o  = en_i && (is8 || is16);
    line_big_o = is16;
  end
endmodule

// File: rtl/burst_sizer.sv
module burst_sizer #(
  parameter int WA_W      = 30,
  parameter int CNT_W     = 16,
  parameter int MAX_BURST = 16,
  localparam int LEN_W    = $clog2(MAX_BURST + 1)
) (
  input  logic [WA_W-1:0]  waddr_i,
  input  logic [CNT_W-1:0] rem_i,
  input  logic             line_ok_i,
  input  logic             line_big_i,
  output logic [LEN_W-1:0] len_o,
  output logic             inval_o
);
  logic [4:0]       line_w;
  logic [4:0]       off;
  logic [4:0]       to_bnd;
  logic [LEN_W-1:0] rem_c;

  always_comb begin
    line_w = line_big_i ? 5'd16 : 5'd8;
    off    = line_big_i ? {1'b0, waddr_i[3:0]} : {2'b00, waddr_i[2:0]};
    to_bnd = line_w - off;
    rem_c  = (rem_i > CNT_W'(MAX_BURST)) ? LEN_W'(MAX_BURST) : LEN_W'(rem_i);
    inval_o = 1'b0;
    len_o   = rem_c;
    if (line_ok_i) begin
      if (off != 5'd0) begin
        // head up to the next boundary
        len_o = (CNT_W'(to_bnd) < rem_i) ? LEN_W'(to_bnd) : rem_c;
      end else if (rem_i >= CNT_W'(line_w)) begin
        len_o   = LEN_W'(line_w);
        inval_o = 1'b1;
      end
    end
  end
endmodule

// File: rtl/wr_cmd_splitter.sv
module wr_cmd_splitter
  import wr_cmd_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int CNT_W     = 16,
  parameter int MAX_BURST = 16,
  localparam int LEN_W    = $clog2(MAX_BURST + 1),
  localparam int WA_W     = ADDR_W - 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [CNT_W-1:0]  req_words_i,
  input  logic              mwi_en_i,
  input  logic [7:0]        line_size_i,
  output logic              burst_start_o,
  output logic [3:0]        burst_cmd_o,
  output logic [LEN_W-1:0]  burst_len_o,
  output logic [ADDR_W-1:0] burst_addr_o
);
  logic             busy_q;
  logic [WA_W-1:0]  waddr_q;
  logic [CNT_W-1:0] rem_q;
  logic             en_q;
  logic [7:0]       size_q;
  logic             line_ok, line_big;
  logic [LEN_W-1:0] len_c;
  logic             inval_c;

  logic              start_q;
  bus_cmd_t          cmd_q;
  logic [LEN_W-1:0]  len_q;
  logic [ADDR_W-1:0] addr_q;

  line_cfg_decode u_dec (
    .en_i      (en_q),
    .size_i    (size_q),
    .line_ok_o (line_ok),
    .line_big_o(line_big)
  );

  burst_sizer #(.WA_W(WA_W), .CNT_W(CNT_W), .MAX_BURST(MAX_BURST)) u_size (
    .waddr_i   (waddr_q),
    .rem_i     (rem_q),
    .line_ok_i (line_ok),
    .line_big_i(line_big),
    .len_o     (len_c),
    .inval_o   (inval_c)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      waddr_q <= '0;
      rem_q   <= '0;
      en_q    <= 1'b0;
      size_q  <= '0;
      start_q <= 1'b0;
      cmd_q   <= CMD_MEM_WR;
      len_q   <= '0;
      addr_q  <= '0;
    end else begin
      start_q <= 1'b0;
      if (!busy_q) begin
        if (req_valid_i && req_words_i != '0) begin
          busy_q  <= 1'b1;
          waddr_q <= req_addr_i[ADDR_W-1:2];
          rem_q   <= req_words_i;
          en_q    <= mwi_en_i;
          size_q  <= line_size_i;
        end
      end else begin
        start_q <= 1'b1;
        cmd_q   <= inval_c ? CMD_MEM_WRI : CMD_MEM_WR;
        len_q   <= len_c;
        addr_q  <= {waddr_q, 2'b00};
        waddr_q <= waddr_q + WA_W'(len_c);
        rem_q   <= rem_q - CNT_W'(len_c);
        if (rem_q == CNT_W'(len_c)) busy_q <= 1'b0;
      end
    end
  end

  assign req_ready_o   = !busy_q;
  assign burst_start_o = start_q;
  assign burst_cmd_o   = cmd_q;
  assign burst_len_o   = len_q;
  assign burst_addr_o  = addr_q;

  // R2, R3: invalidate only with enable and a supported size
  a_r2_inval_needs_cfg: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (burst_start_o && burst_cmd_o == CMD_MEM_WRI) |-> (en_q && (size_q == LSZ_8W || size_q == LSZ_16W)));

  // R4: invalidate covers one aligned line
  a_r4_inval_whole_line: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (burst_start_o && burst_cmd_o == CMD_MEM_WRI) |->
      ((size_q == LSZ_16W) ? (burst_len_o == LEN_W'(16) && burst_addr_o[5:0] == 6'd0)
                           : (burst_len_o == LEN_W'(8)  && burst_addr_o[4:0] == 5'd0)));

  // R7: burst length within remainder and cap
  a_r7_len_bounds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> (len_c != '0 && CNT_W'(len_c) <= rem_q && len_c <= LEN_W'(MAX_BURST)));

  // R8: only the two command codes appear
  a_r8_cmd_code: assert property (@(posedge clk_i) disable iff (!rst_ni)
    burst_start_o |-> (burst_cmd_o == CMD_MEM_WR || burst_cmd_o == CMD_MEM_WRI));

  // R9: consecutive bursts advance by their length
  a_r9_addr_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (burst_start_o && $past(burst_start_o)) |->
      (burst_addr_o == $past(burst_addr_o) + ADDR_W'({$past(burst_len_o), 2'b00})));

  // R10: zero-count request leaves the block idle
  a_r10_zero_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_ready_o && req_valid_i && req_words_i == '0) |=> (req_ready_o && !burst_start_o));
endmodule

// File: tb/wr_cmd_splitter_bench.sv
module wr_cmd_splitter_bench;
  localparam int AW = 32, CW = 16, MB = 16, LW = 5;

  logic          clk_i = 1'b0, rst_ni = 1'b0;
  logic          req_valid_i = 1'b0, req_ready_o;
  logic [AW-1:0] req_addr_i = '0;
  logic [CW-1:0] req_words_i = '0;
  logic          mwi_en_i = 1'b0;
  logic [7:0]    line_size_i = '0;
  logic          burst_start_o;
  logic [3:0]    burst_cmd_o;
  logic [LW-1:0] burst_len_o;
  logic [AW-1:0] burst_addr_o;

  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #4 clk_i = ~clk_i;

  wr_cmd_splitter u_wr_cmd_splitter (.*);

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Issue one request and compare every burst with the model
  task automatic xfer(input bit en, input logic [7:0] lsz, input logic [AW-1:0] addr,
                      input int words, input bit poke);
    int rem = words;
    logic [AW-1:0] a = addr;
    bit ok_line = en && (lsz == 8'h08 || lsz == 8'h10);
    int lw = (lsz == 8'h10) ? 16 : 8;
    @(negedge clk_i);
    req_valid_i = 1; req_addr_i = addr; req_words_i = CW'(words);
    mwi_en_i = en; line_size_i = lsz;
    @(negedge clk_i);
    if (poke) begin
      // R11: a different request held while busy
      req_valid_i = 1; req_addr_i = 32'h0000_4000; req_words_i = 16'd3;
      mwi_en_i = ~en; line_size_i = 8'h08;
    end else req_valid_i = 0;
    if (words == 0) begin
      chk(req_ready_o && !burst_start_o, "R10", {req_ready_o, burst_start_o}, 2'b10);
      req_valid_i = 0;
      return;
    end
    while (rem > 0) begin
      int off = (a >> 2) % lw;
      int el;
      logic [3:0] ec;
      ec = 4'b0111;
      el = (rem > MB) ? MB : rem;
      if (ok_line) begin
        if (off != 0) el = (lw - off < rem) ? lw - off : rem;      // R5
        else if (rem >= lw) begin el = lw; ec = 4'b1111; end        // R4
        else el = rem;                                              // R6
      end
      if (rem == el && poke) req_valid_i = 0;
      @(posedge clk_i); #1;
      chk(burst_start_o, "R9 strobe", burst_start_o, 1);
      chk(burst_cmd_o == ec, en ? (ok_line ? "R4 cmd" : "R3 cmd") : "R2 cmd", burst_cmd_o, ec);
      chk(burst_len_o == LW'(el), ok_line ? "R5/R6 len" : "R7 len", burst_len_o, el);
      chk(burst_addr_o == a, "R9 addr", burst_addr_o, a);
      a = a + 32'(el * 4);
      rem -= el;
      chk(req_ready_o == (rem == 0), "R9 ready", req_ready_o, rem == 0);
    end
    req_valid_i = 0;
    @(posedge clk_i); #1;
    chk(!burst_start_o, "R9 end", burst_start_o, 0);
  endtask

  initial begin
    void'($urandom(32'd1234));
    #2; #20;
    chk(req_ready_o == 1 && burst_start_o == 0, "R1", {req_ready_o, burst_start_o}, 2'b10);
    rst_ni = 1;
    // directed corners
    xfer(1, 8'h08, 32'h100, 8, 0);      // R4 one whole line
    xfer(1, 8'h10, 32'h104, 40, 0);     // R5 head, R4 lines, R6 tail
    xfer(1, 8'h10, 32'h108, 3, 0);      // R5 head capped by count
    xfer(1, 8'h08, 32'h200, 13, 0);     // R6 tail
    xfer(0, 8'h10, 32'h400, 40, 0);     // R2 disabled
    xfer(1, 8'h20, 32'h400, 40, 0);     // R3 size 32
    xfer(1, 8'h04, 32'h400, 9, 0);      // R3 size 4
    xfer(1, 8'h00, 32'h400, 17, 0);     // R3 size 0
    xfer(1, 8'h18, 32'h400, 33, 0);     // R3 size 24, R7
    xfer(1, 8'h08, 32'h300, 0, 0);      // R10
    xfer(1, 8'h08, 32'h31c, 30, 1);     // R11
    xfer(0, 8'h08, 32'h31c, 33, 1);     // R11, R8 plain
    for (int i = 0; i < 60; i++) begin
      int pick = $urandom_range(0, 5);
      logic [7:0] sz = (pick < 2) ? 8'h08 : (pick < 4) ? 8'h10 : 8'($urandom_range(0, 255));
      xfer($urandom_range(0, 3) != 0, sz, {12'h0, 18'($urandom), 2'b00},
           $urandom_range(0, 80), $urandom_range(0, 3) == 0);
    end
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk_i);
        n_run++; n_fail++;
        $display("FAIL watchdog actual=running expected=done");
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule